// File: doc/BRIEF.md
# Serial Bus Gap-Count Controller

This block keeps the configuration register of a serial-bus physical layer: a root-holdoff flag, a self-clearing reset-initiate bit and a six-bit gap count. A link-layer host writes and reads the register. Configuration packets also load the root-holdoff flag and the gap count, whether the node sends them or receives them. When the host sets the reset-initiate bit, the block asks the physical layer to start a bus reset.

A one-bit tracker records whether the gap count has been loaded since the last bus reset. A bus reset with no load since the previous one returns the gap count to its maximum, 63. This lets software send a configuration packet and then reset the bus to confirm the new gap count on every node. A later reset caused by a node joining the bus still restores the default.

Top module: `gap_cfg_ctrl`

## Requirements
- R1: After power-on reset the gap count is 63, root-holdoff is 0, the reset request is low and the read-back value is 0x3F.
- R2: A host write updates root-holdoff (data bit 7) and the gap count (data bits 5..0) together. The new values appear on the outputs in the cycle after the write.
- R3: The read-back value is {root-holdoff, 0, gap count}, so the reset-initiate bit (bit 6) always reads as 0.
- R4: A host write with data bit 6 set drives the reset request high for exactly the one cycle after the write. A write with bit 6 clear raises no request.
- R5: A transmitted configuration packet strobe loads root-holdoff and the gap count from its fields, and the values can be read back at once.
- R6: A received configuration packet strobe loads root-holdoff and the gap count from its fields.
- R7: When several loads arrive in the same cycle, a host write wins over a transmitted packet, and a transmitted packet wins over a received one.
- R8: A bus reset that follows a load, including a load by the write that requested the reset, leaves the gap count and root-holdoff unchanged.
- R9: A bus reset with no load since the previous bus reset (or since power-on) sets the gap count to 63 and leaves root-holdoff unchanged.
- R10: If a load and a bus-reset pulse arrive in the same cycle, the load takes effect and still counts as an update for the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 8 | Host write data {rhb, initiate, gap} |
| host_rdata | output | 8 | Register read-back {rhb, 0, gap} |
| txcfg_vld | input | 1 | Configuration packet transmitted |
| txcfg_rhb | input | 1 | Root-holdoff field of transmitted packet |
| txcfg_gap | input | 6 | Gap field of transmitted packet |
| rxcfg_vld | input | 1 | Configuration packet received |
| rxcfg_rhb | input | 1 | Root-holdoff field of received packet |
| rxcfg_gap | input | 6 | Gap field of received packet |
| bus_rst_seen | input | 1 | One-cycle pulse when a bus reset occurred |
| gap_count | output | 6 | Current gap count |
| root_holdoff | output | 1 | Current root-holdoff flag |
| bus_rst_req | output | 1 | Request to start a bus reset |

## Verification
The assertions check four things on every cycle. Any accepted load appears in the register one cycle later and sets the update flag. A reset-initiate write is followed by a request. A bus reset either holds the register or forces the gap count to 63, depending on the update flag. The bench scenarios show what the assertions cannot. These are the read-back format, the priority among loads that arrive together, the exact one-cycle length of the request, and the full sequence of load, reset, reset across several rounds, including a load and a reset in the same cycle.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  parameter int GAP_W = 6;
  localparam int REG_W = GAP_W + 2;
  localparam int BIT_RHB = REG_W - 1;
  localparam int BIT_INIT = REG_W - 2;
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  typedef struct packed {
    logic             vld;
    logic             rhb;
    logic [GAP_W-1:0] gap;
  } gcc_load_t;
endpackage

// File: rtl/gcc_load_arb.sv
module gcc_load_arb
  import gcc_pkg::*;
(
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  input  logic             txcfg_vld,
  input  logic             txcfg_rhb,
  input  logic [GAP_W-1:0] txcfg_gap,
  input  logic             rxcfg_vld,
  input  logic             rxcfg_rhb,
  input  logic [GAP_W-1:0] rxcfg_gap,
  output gcc_load_t        ld
);
  localparam int NSRC = 3;
  gcc_load_t src [NSRC];

  always_comb begin
    src[0] = '{vld: host_wr, rhb: host_wdata[BIT_RHB], gap: host_wdata[GAP_W-1:0]};
    src[1] = '{vld: txcfg_vld, rhb: txcfg_rhb, gap: txcfg_gap};
    src[2] = '{vld: rxcfg_vld, rhb: rxcfg_rhb, gap: rxcfg_gap};
  end

  // lowest index has highest priority
  always_comb begin
    ld = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src[i].vld) ld = src[i];
    end
  end
endmodule

// File: rtl/gcc_reset_track.sv
module gcc_reset_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_vld,
  input  logic bus_rst,
  output logic upd_flag,
  output logic force_max
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (ld_vld)       flag_d = 1'b1;
    else if (bus_rst) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign upd_flag  = flag_q;
  assign force_max = bus_rst & ~ld_vld & ~flag_q;

  // R10: a load always arms the flag, even alongside a bus reset
  p_flag_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |=> upd_flag);
endmodule

// File: rtl/gcc_cfg_reg.sv
module gcc_cfg_reg
  import gcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  gcc_load_t        ld,
  input  logic             force_max,
  output logic             rhb,
  output logic [GAP_W-1:0] gap
);
  logic             rhb_q, rhb_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    rhb_d = rhb_q;
    gap_d = gap_q;
    if (ld.vld) begin
      rhb_d = ld.rhb;
      gap_d = ld.gap;
    end else if (force_max) begin
      gap_d = GAP_MAX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rhb_q <= 1'b0;
      gap_q <= GAP_MAX;
    end else begin
      rhb_q <= rhb_d;
      gap_q <= gap_d;
    end
  end

  assign rhb = rhb_q;
  assign gap = gap_q;

  // R2: accepted load lands in the register one cycle later
  p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld.vld |=> (gap == $past(ld.gap)) && (rhb == $past(ld.rhb)));
endmodule

// File: rtl/gcc_reset_req.sv
module gcc_reset_req
  import gcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic init_bit,
  output logic req
);
  logic req_q, req_d;

  always_comb req_d = host_wr & init_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

  // R4: reset-initiate write produces a request next cycle
  p_req_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && init_bit) |=> req);
endmodule

// File: rtl/gap_cfg_ctrl.sv
module gap_cfg_ctrl
  import gcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             txcfg_vld,
  input  logic             txcfg_rhb,
  input  logic [GAP_W-1:0] txcfg_gap,
  input  logic             rxcfg_vld,
  input  logic             rxcfg_rhb,
  input  logic [GAP_W-1:0] rxcfg_gap,
  input  logic             bus_rst_seen,
  output logic [GAP_W-1:0] gap_count,
  output logic             root_holdoff,
  output logic             bus_rst_req
);
  gcc_load_t ld;
  logic      upd_flag;
  logic      force_max;

  gcc_load_arb u_arb (
    .host_wr(host_wr), .host_wdata(host_wdata),
    .txcfg_vld(txcfg_vld), .txcfg_rhb(txcfg_rhb), .txcfg_gap(txcfg_gap),
    .rxcfg_vld(rxcfg_vld), .rxcfg_rhb(rxcfg_rhb), .rxcfg_gap(rxcfg_gap),
    .ld(ld)
  );

  gcc_reset_track u_track (
    .clk(clk), .rst_n(rst_n), .ld_vld(ld.vld), .bus_rst(bus_rst_seen),
    .upd_flag(upd_flag), .force_max(force_max)
  );

  gcc_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .ld(ld), .force_max(force_max),
    .rhb(root_holdoff), .gap(gap_count)
  );

  gcc_reset_req u_req (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr),
    .init_bit(host_wdata[BIT_INIT]), .req(bus_rst_req)
  );

  assign host_rdata = {root_holdoff, 1'b0, gap_count};

  // R9: reset with no update since the last one forces maximum gap
  p_force_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_seen && !ld.vld && !upd_flag) |=> (gap_count == GAP_MAX) && $stable(root_holdoff));

  // R8: reset after an update keeps the register
  p_hold_after_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_seen && !ld.vld && upd_flag) |=> $stable(gap_count) && $stable(root_holdoff));
endmodule

// File: tb/gap_cfg_ctrl_bench.sv
`timescale 1ns/1ps
module gap_cfg_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       txcfg_vld, txcfg_rhb, rxcfg_vld, rxcfg_rhb;
  logic [5:0] txcfg_gap, rxcfg_gap;
  logic       bus_rst_seen;
  logic [5:0] gap_count;
  logic       root_holdoff, bus_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gap_cfg_ctrl u_gap_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .txcfg_vld(txcfg_vld), .txcfg_rhb(txcfg_rhb),
    .txcfg_gap(txcfg_gap), .rxcfg_vld(rxcfg_vld), .rxcfg_rhb(rxcfg_rhb),
    .rxcfg_gap(rxcfg_gap), .bus_rst_seen(bus_rst_seen), .gap_count(gap_count),
    .root_holdoff(root_holdoff), .bus_rst_req(bus_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_wdata = '0; txcfg_vld = 0; txcfg_rhb = 0; txcfg_gap = '0;
    rxcfg_vld = 0; rxcfg_rhb = 0; rxcfg_gap = '0; bus_rst_seen = 0;
  endtask

  // inputs are set before calling; one edge consumes them, then sample
  task automatic cycle();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [7:0] d);
    host_wr = 1; host_wdata = d; cycle();
  endtask

  task automatic brst();
    bus_rst_seen = 1; cycle();
  endtask

  task automatic t_reset_state();
    check("R1 gap", gap_count, 63);
    check("R1 rhb", root_holdoff, 0);
    check("R1 req", bus_rst_req, 0);
    check("R1 rdata", host_rdata, 8'h3F);
  endtask

  task automatic t_host_write();
    wr(8'h95);
    check("R2 gap", gap_count, 21);
    check("R2 rhb", root_holdoff, 1);
    check("R3 rdata", host_rdata, 8'h95);
    check("R4 no req", bus_rst_req, 0);
    wr(8'hEA);
    check("R3 init reads 0", host_rdata, 8'hAA);
    check("R4 req high", bus_rst_req, 1);
    cycle();
    check("R4 req one cycle", bus_rst_req, 0);
  endtask

  task automatic t_packets();
    txcfg_vld = 1; txcfg_rhb = 1; txcfg_gap = 6'd12; cycle();
    check("R5 tx rdata", host_rdata, 8'h8C);
    rxcfg_vld = 1; rxcfg_rhb = 0; rxcfg_gap = 6'd33; cycle();
    check("R6 rx rdata", host_rdata, 8'h21);
  endtask

  task automatic t_priority();
    host_wr = 1; host_wdata = 8'h03;
    txcfg_vld = 1; txcfg_gap = 6'd4; txcfg_rhb = 1;
    rxcfg_vld = 1; rxcfg_gap = 6'd5; rxcfg_rhb = 1; cycle();
    check("R7 write wins", host_rdata, 8'h03);
    txcfg_vld = 1; txcfg_gap = 6'd4; txcfg_rhb = 0;
    rxcfg_vld = 1; rxcfg_gap = 6'd5; rxcfg_rhb = 1; cycle();
    check("R7 tx wins", host_rdata, 8'h04);
  endtask

  task automatic t_reset_rules();
    wr(8'h0A);
    brst();
    check("R8 hold after write", gap_count, 10);
    brst();
    check("R9 forced max", gap_count, 63);
    wr(8'hCB);
    check("R4 req on init write", bus_rst_req, 1);
    brst();
    check("R8 init write keeps gap", host_rdata, 8'h8B);
    txcfg_vld = 1; txcfg_rhb = 1; txcfg_gap = 6'd7; cycle();
    brst();
    check("R8 hold after tx", host_rdata, 8'h87);
    brst();
    check("R9 forced max rhb kept", host_rdata, 8'hBF);
  endtask

  task automatic t_collide();
    brst();
    rxcfg_vld = 1; rxcfg_rhb = 0; rxcfg_gap = 6'd20; bus_rst_seen = 1; cycle();
    check("R10 load wins", gap_count, 20);
    brst();
    check("R10 flag armed", gap_count, 20);
    brst();
    check("R9 after collide", gap_count, 63);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_host_write();
    t_packets();
    t_priority();
    t_reset_rules();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule